// File: doc/BRIEF.md
# NAND Boot Header Probe

This block discovers how an attached NAND flash must be accessed and decodes the boot header held in its first sector. After a start pulse, and only when the presence input is high, it asks an external sector reader for sector 0 under access type 0. It takes the 512 returned bytes and checks them for the header signature. If the signature is absent, it repeats the request with the next access type, up to type 5.

When a try matches, the block registers the decoded header and holds it until the next start pulse. The decoded header gives the access type word, page and spare size, address byte count, block and flash size exponents, access time and boot sector count. When no flash is present it reports that instead. When all six tries miss it raises a failure flag.

Both data-carrying edges use valid/ready. A sector request (`rd_req_valid`, `rd_req_type`) stays asserted, with its type unchanged, until the reader raises `rd_req_ready`. Sector bytes move only in cycles where `rd_data_valid` and `rd_data_ready` are both high. The block raises `rd_data_ready` only while a sector is in flight, and holds it high for the whole sector. The reader may stall by dropping `rd_data_valid` at any time.

Top module: `nand_boot_probe`

## Requirements
- R1: A start pulse seen while `present` is low issues no sector request. One cycle later `done` and `no_flash` are high and `hdr_valid` is low.
- R2: Access types are requested in increasing order starting at 0, with exactly one request per try, and `rd_req_type` carries the try number.
- R3: A sector matches only if bytes 0..3 are 0x56, 0x4C, 0x4E, 0x35. A difference in any one of these bytes makes the try a miss. On a match, `found_type` reports the try number.
- R4: Every try takes exactly 512 bytes, even after an early mismatch. No new request is raised while `rd_data_ready` is high, and `rd_data_ready` drops after the 512th byte.
- R5: The header fields are decoded as follows. `hdr_type` is byte 4 (low) and byte 5 (high). `block_exp` is byte 6 and `flash_exp` is byte 7. `access_ns` is bytes 8 (low) and 9 (high). The extra count is bytes 10 (low) and 11 (high).
- R6: The low type byte selects the geometry. Bit 0 clear gives a 512-byte page with 16 spare bytes. Bit 0 set gives a 2048-byte page with 64 spare bytes. `addr_bytes` is 2 plus bits 2:1 of the low type byte, so codes 0/1 give 2, codes 2/3 give 3 and codes 4/5 give 4.
- R7: When bytes 12..15 are 0x42, 0x6F, 0x4F, 0x74, `boot_sectors` is the extra count plus one (17 bits wide) and `no_boot_code` is low.
- R8: When bytes 12..15 differ from that pattern, `boot_sectors` is 0 and `no_boot_code` is high.
- R9: If none of the six tries matches, `probe_fail` and `done` go high and `hdr_valid` stays low.
- R10: The results and `done` are held unchanged until the next start pulse, which clears `done` and `hdr_valid`. Activity on the data inputs while idle has no effect on them.
- R11: A request held without `rd_req_ready` stays asserted with a stable type, and stalls on the byte stream do not change the decoded result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| present | input | 1 | Flash presence (chip-select sense) |
| rd_req_valid | output | 1 | Sector-0 read request valid |
| rd_req_ready | input | 1 | Reader accepts the request |
| rd_req_type | output | 3 | Access type for this read |
| rd_data_valid | input | 1 | Sector byte valid |
| rd_data_ready | output | 1 | Block accepts a sector byte |
| rd_data | input | 8 | Sector byte |
| busy | output | 1 | Probe in progress |
| done | output | 1 | Probe finished, results held |
| no_flash | output | 1 | Presence input was low at start |
| probe_fail | output | 1 | No access type matched |
| hdr_valid | output | 1 | Decoded header outputs are valid |
| no_boot_code | output | 1 | Boot ident bytes absent |
| found_type | output | 3 | Try number that matched |
| hdr_type | output | 16 | Type word from the header |
| page_bytes | output | 12 | Data bytes per page |
| spare_bytes | output | 7 | Spare bytes per page |
| addr_bytes | output | 3 | Address byte count |
| block_exp | output | 8 | Block size exponent (units of 512 bytes) |
| flash_exp | output | 8 | Flash size exponent (units of 512 bytes) |
| access_ns | output | 16 | Access time in ns |
| boot_sectors | output | 17 | Sectors of boot code to load |

## Verification
The bench varies which try carries the signature, from the first to the last, and includes a run where none does. A design that stops early, skips a type or mis-orders types shows the wrong request sequence or try count.

Mismatching sectors differ from the signature only in byte 3, with a 0x45 value at try 5. A design that checks just the first bytes, or that resynchronises without draining the full 512 bytes, matches the wrong try or hangs.

Some vectors have a header type word that differs from the try number, a non-zero high type byte, an extra count of 0xFFFF, and a corrupted boot ident. These expose decoding from the wrong byte, a 16-bit overflow of the sector count, and a missing no-boot flag. Stalled handshakes and idle input activity expose a request that drops early and results that are not held.

// File: rtl/nbp_pkg.sv
package nbp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_RECV  = 2'd2,
    ST_CHECK = 2'd3
  } probe_state_e;

  localparam int HDR_LEN      = 16;
  localparam int SIG_FIRST    = 0;
  localparam int IDENT_FIRST  = 12;
  localparam int SMALL_PAGE   = 512;
  localparam int SMALL_SPARE  = 16;
  localparam int LARGE_PAGE   = 2048;
  localparam int LARGE_SPARE  = 64;
  localparam int MIN_ADDR_B   = 2;

  // Signature expected at the start of sector 0
  function automatic logic [7:0] sig_byte(input logic [1:0] k);
    case (k)
      2'd0:    sig_byte = 8'h56;
      2'd1:    sig_byte = 8'h4C;
      2'd2:    sig_byte = 8'h4E;
      default: sig_byte = 8'h35;
    endcase
  endfunction

  // Optional boot ident pattern
  function automatic logic [7:0] ident_byte(input logic [1:0] k);
    case (k)
      2'd0:    ident_byte = 8'h42;
      2'd1:    ident_byte = 8'h6F;
      2'd2:    ident_byte = 8'h4F;
      default: ident_byte = 8'h74;
    endcase
  endfunction

endpackage

// File: rtl/nbp_hdr_capture.sv
module nbp_hdr_capture
  import nbp_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        beat,
  input  logic [7:0]  byte_in,
  output logic        last_beat,
  output logic        sig_match,
  output logic        ident_match,
  output logic [15:0] f_type,
  output logic [7:0]  f_blk,
  output logic [7:0]  f_flash,
  output logic [15:0] f_ns,
  output logic [15:0] f_extra
);
  localparam int IDX_W = $clog2(SECTOR_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTOR_BYTES - 1);

  logic [IDX_W-1:0] idx_q;
  logic [7:0]       hdr_q [HDR_LEN];

  assign last_beat = beat && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idx_q <= '0;
    else if (clear)     idx_q <= '0;
    else if (last_beat) idx_q <= '0;
    else if (beat)      idx_q <= idx_q + 1'b1;
  end

  // One capture register per header byte
  for (genvar g = 0; g < HDR_LEN; g++) begin : g_hdr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                hdr_q[g] <= '0;
      else if (beat && idx_q == IDX_W'(g))       hdr_q[g] <= byte_in;
    end
  end

  logic in_sig, in_ident;
  assign in_sig   = (idx_q < IDX_W'(SIG_FIRST + 4));
  assign in_ident = (idx_q >= IDX_W'(IDENT_FIRST)) && (idx_q < IDX_W'(IDENT_FIRST + 4));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_match   <= 1'b0;
      ident_match <= 1'b0;
    end else if (clear) begin
      sig_match   <= 1'b1;
      ident_match <= 1'b1;
    end else if (beat) begin
      if (in_sig && byte_in != sig_byte(idx_q[1:0]))
        sig_match <= 1'b0;
      if (in_ident && byte_in != ident_byte(idx_q[1:0]))
        ident_match <= 1'b0;
    end
  end

  assign f_type  = {hdr_q[5], hdr_q[4]};
  assign f_blk   = hdr_q[6];
  assign f_flash = hdr_q[7];
  assign f_ns    = {hdr_q[9], hdr_q[8]};
  assign f_extra = {hdr_q[11], hdr_q[10]};

endmodule

// File: rtl/nbp_geom_decode.sv
module nbp_geom_decode
  import nbp_pkg::*;
(
  input  logic [7:0]  type_lo,
  input  logic [15:0] extra,
  input  logic        ident_ok,
  output logic [11:0] page_bytes,
  output logic [6:0]  spare_bytes,
  output logic [2:0]  addr_bytes,
  output logic [16:0] boot_sectors
);
  always_comb begin
    if (type_lo[0]) begin
      page_bytes  = 12'(LARGE_PAGE);
      spare_bytes = 7'(LARGE_SPARE);
    end else begin
      page_bytes  = 12'(SMALL_PAGE);
      spare_bytes = 7'(SMALL_SPARE);
    end
    addr_bytes   = 3'(MIN_ADDR_B) + {1'b0, type_lo[2:1]};
    boot_sectors = ident_ok ? ({1'b0, extra} + 17'd1) : 17'd0;
  end
endmodule

// File: rtl/nand_boot_probe.sv
module nand_boot_probe
  import nbp_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int NUM_TYPES    = 6,
  parameter int TYPE_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              present,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [TYPE_W-1:0] rd_req_type,
  input  logic              rd_data_valid,
  output logic              rd_data_ready,
  input  logic [7:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic              no_flash,
  output logic              probe_fail,
  output logic              hdr_valid,
  output logic              no_boot_code,
  output logic [TYPE_W-1:0] found_type,
  output logic [15:0]       hdr_type,
  output logic [11:0]       page_bytes,
  output logic [6:0]        spare_bytes,
  output logic [2:0]        addr_bytes,
  output logic [7:0]        block_exp,
  output logic [7:0]        flash_exp,
  output logic [15:0]       access_ns,
  output logic [16:0]       boot_sectors
);
  localparam logic [TYPE_W-1:0] LAST_TRY = TYPE_W'(NUM_TYPES - 1);

  probe_state_e      state_q;
  logic [TYPE_W-1:0] try_q;

  logic        cap_clear, cap_beat, cap_last, cap_sig, cap_ident;
  logic [15:0] cap_type, cap_ns, cap_extra;
  logic [7:0]  cap_blk, cap_flash;
  logic [11:0] dec_page;
  logic [6:0]  dec_spare;
  logic [2:0]  dec_addr;
  logic [16:0] dec_boot;

  assign rd_req_valid  = (state_q == ST_REQ);
  assign rd_req_type   = try_q;
  assign rd_data_ready = (state_q == ST_RECV);
  assign busy          = (state_q != ST_IDLE);
  assign cap_clear     = rd_req_valid && rd_req_ready;
  assign cap_beat      = rd_data_ready && rd_data_valid;

  nbp_hdr_capture #(.SECTOR_BYTES(SECTOR_BYTES)) cap_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (cap_clear),
    .beat       (cap_beat),
    .byte_in    (rd_data),
    .last_beat  (cap_last),
    .sig_match  (cap_sig),
    .ident_match(cap_ident),
    .f_type     (cap_type),
    .f_blk      (cap_blk),
    .f_flash    (cap_flash),
    .f_ns       (cap_ns),
    .f_extra    (cap_extra)
  );

  nbp_geom_decode dec_i (
    .type_lo     (cap_type[7:0]),
    .extra       (cap_extra),
    .ident_ok    (cap_ident),
    .page_bytes  (dec_page),
    .spare_bytes (dec_spare),
    .addr_bytes  (dec_addr),
    .boot_sectors(dec_boot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      try_q        <= '0;
      done         <= 1'b0;
      no_flash     <= 1'b0;
      probe_fail   <= 1'b0;
      hdr_valid    <= 1'b0;
      no_boot_code <= 1'b0;
      found_type   <= '0;
      hdr_type     <= '0;
      page_bytes   <= '0;
      spare_bytes  <= '0;
      addr_bytes   <= '0;
      block_exp    <= '0;
      flash_exp    <= '0;
      access_ns    <= '0;
      boot_sectors <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            done         <= !present;
            no_flash     <= !present;
            probe_fail   <= 1'b0;
            hdr_valid    <= 1'b0;
            no_boot_code <= 1'b0;
            try_q        <= '0;
            if (present) state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (rd_req_ready) state_q <= ST_RECV;
        end
        ST_RECV: begin
          if (cap_last) state_q <= ST_CHECK;
        end
        default: begin
          if (cap_sig) begin
            hdr_valid    <= 1'b1;
            done         <= 1'b1;
            no_boot_code <= !cap_ident;
            found_type   <= try_q;
            hdr_type     <= cap_type;
            page_bytes   <= dec_page;
            spare_bytes  <= dec_spare;
            addr_bytes   <= dec_addr;
            block_exp    <= cap_blk;
            flash_exp    <= cap_flash;
            access_ns    <= cap_ns;
            boot_sectors <= dec_boot;
            state_q      <= ST_IDLE;
          end else if (try_q == LAST_TRY) begin
            probe_fail <= 1'b1;
            done       <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            try_q   <= try_q + 1'b1;
            state_q <= ST_REQ;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/nbp_probe_chk.sv
module nbp_probe_chk #(
  parameter int TYPE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              present,
  input logic              busy,
  input logic              done,
  input logic              no_flash,
  input logic              probe_fail,
  input logic              hdr_valid,
  input logic              no_boot_code,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [TYPE_W-1:0] rd_req_type,
  input logic              rd_data_ready,
  input logic [16:0]       boot_sectors
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_type));

  // R4
  req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_ready |-> !rd_req_valid);

  // R1
  absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !present |=> no_flash && done && !hdr_valid && !rd_req_valid);

  // R9
  fail_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_fail |-> !hdr_valid);

  // R8
  noboot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && no_boot_code |-> boot_sectors == 17'd0);

  // R7
  boot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !no_boot_code |-> boot_sectors != 17'd0);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(hdr_valid) && $stable(boot_sectors));
endmodule

bind nand_boot_probe nbp_probe_chk #(.TYPE_W(TYPE_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .present      (present),
  .busy         (busy),
  .done         (done),
  .no_flash     (no_flash),
  .probe_fail   (probe_fail),
  .hdr_valid    (hdr_valid),
  .no_boot_code (no_boot_code),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_type  (rd_req_type),
  .rd_data_ready(rd_data_ready),
  .boot_sectors (boot_sectors)
);

// File: tb/nand_boot_probe_tb_top.sv
module nand_boot_probe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SECTOR     = 512;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n, start, present;
  logic        rd_req_valid, rd_req_ready;
  logic [2:0]  rd_req_type;
  logic        rd_data_valid, rd_data_ready;
  logic [7:0]  rd_data;
  logic        busy, done, no_flash, probe_fail, hdr_valid, no_boot_code;
  logic [2:0]  found_type;
  logic [15:0] hdr_type, access_ns;
  logic [11:0] page_bytes;
  logic [6:0]  spare_bytes;
  logic [2:0]  addr_bytes;
  logic [7:0]  block_exp, flash_exp;
  logic [16:0] boot_sectors;

  nand_boot_probe dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .present(present),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_type(rd_req_type),
    .rd_data_valid(rd_data_valid), .rd_data_ready(rd_data_ready), .rd_data(rd_data),
    .busy(busy), .done(done), .no_flash(no_flash), .probe_fail(probe_fail),
    .hdr_valid(hdr_valid), .no_boot_code(no_boot_code), .found_type(found_type),
    .hdr_type(hdr_type), .page_bytes(page_bytes), .spare_bytes(spare_bytes),
    .addr_bytes(addr_bytes), .block_exp(block_exp), .flash_exp(flash_exp),
    .access_ns(access_ns), .boot_sectors(boot_sectors)
  );

  typedef struct packed {
    logic [2:0]  good;   // try carrying the signature, 6 = none
    logic [7:0]  tlo;
    logic [7:0]  thi;
    logic [7:0]  blk;
    logic [7:0]  fl;
    logic [15:0] ns;
    logic [15:0] extra;
    logic        boot;
    logic        stall;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'd0, 8'h00, 8'd5,  8'd15,   16'd50,     16'd0,      1'b1, 1'b0},
    '{3'd1, 8'd1, 8'h00, 8'd6,  8'd17,   16'd25,     16'd1,      1'b1, 1'b1},
    '{3'd2, 8'd2, 8'h12, 8'd7,  8'd20,   16'h0123,   16'd3,      1'b0, 1'b0},
    '{3'd3, 8'd3, 8'h00, 8'd8,  8'h13,   16'h0046,   16'd1,      1'b1, 1'b1},
    '{3'd4, 8'd4, 8'h00, 8'd9,  8'd24,   16'hBEEF,   16'hFFFF,   1'b1, 1'b0},
    '{3'd5, 8'd5, 8'h00, 8'd10, 8'd26,   16'd70,     16'd2,      1'b1, 1'b0},
    '{3'd6, 8'd0, 8'h00, 8'd0,  8'd0,    16'd0,      16'd0,      1'b0, 1'b0},
    '{3'd5, 8'd0, 8'h00, 8'd4,  8'd12,   16'd9,      16'd7,      1'b0, 1'b1}
  };

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sec_byte(input int idx, input int tr, input vec_t v);
    logic [7:0] b;
    b = idx[7:0] ^ 8'hA5;
    if (tr == int'(v.good)) begin
      case (idx)
        0: b = 8'h56;  1: b = 8'h4C;  2: b = 8'h4E;  3: b = 8'h35;
        4: b = v.tlo;  5: b = v.thi;  6: b = v.blk;  7: b = v.fl;
        8: b = v.ns[7:0];     9: b = v.ns[15:8];
        10: b = v.extra[7:0]; 11: b = v.extra[15:8];
        12: b = 8'h42; 13: b = 8'h6F; 14: b = 8'h4F;
        15: b = v.boot ? 8'h74 : 8'h78;
        default: b = idx[7:0];
      endcase
    end else begin
      case (idx)
        0: b = 8'h56;  1: b = 8'h4C;  2: b = 8'h4E;
        3: b = 8'h40 + 8'(tr);  // differs only in the last signature byte
        default: ;
      endcase
    end
    return b;
  endfunction

  task automatic stream(input vec_t v, input int tr);
    int idx = 0;
    int cnt = 0;
    bit acc;
    while (idx < SECTOR) begin
      if (v.stall && (cnt % 4 == 1)) rd_data_valid = 1'b0;
      else begin
        rd_data_valid = 1'b1;
        rd_data       = sec_byte(idx, tr, v);
      end
      cnt++;
      if (rd_req_valid) chk("R4 request raised mid-sector", 1, 0);
      acc = rd_data_valid && rd_data_ready;
      @(negedge clk);
      if (acc) idx++;
    end
    rd_data_valid = 1'b0;
    chk("R4 ready drops after 512th byte", rd_data_ready, 0);
  endtask

  task automatic run_probe(input vec_t v, output int tries);
    bit fin = 0;
    tries = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (present) begin
      chk("R10 start clears hdr_valid", hdr_valid, 0);
      chk("R10 start clears done", done, 0);
    end
    while (!fin) begin
      if (done) fin = 1;
      else if (rd_req_valid) begin
        chk("R2 request type order", rd_req_type, tries);
        if (v.stall) begin
          @(negedge clk);
          chk("R11 request held valid", rd_req_valid, 1);
          chk("R11 request type stable", rd_req_type, tries);
        end
        rd_req_ready = 1'b1;
        @(negedge clk) rd_req_ready = 1'b0;
        stream(v, tries);
        tries++;
      end else @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int tries;
    vec_t v, held;
    logic [16:0] exp_boot;
    rst_n = 1'b0; start = 1'b0; present = 1'b0;
    rd_req_ready = 1'b0; rd_data_valid = 1'b0; rd_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset done low", done, 0);
    chk("reset hdr_valid low", hdr_valid, 0);
    chk("reset no request", rd_req_valid, 0);
    chk("reset data_ready low", rd_data_ready, 0);

    // R1: absent flash
    present = 1'b0;
    run_probe(VECS[0], tries);
    chk("R1 no_flash", no_flash, 1);
    chk("R1 done", done, 1);
    chk("R1 hdr_valid low", hdr_valid, 0);
    chk("R1 no request issued", tries, 0);

    present = 1'b1;
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      run_probe(v, tries);
      chk("R1 no_flash low when present", no_flash, 0);
      if (v.good > 3'd5) begin
        chk("R9 six tries", tries, 6);
        chk("R9 probe_fail", probe_fail, 1);
        chk("R9 hdr_valid low", hdr_valid, 0);
      end else begin
        exp_boot = v.boot ? ({1'b0, v.extra} + 17'd1) : 17'd0;
        chk("R2 tries until match", tries, int'(v.good) + 1);
        chk("R3 hdr_valid", hdr_valid, 1);
        chk("R3 found_type", found_type, v.good);
        chk("R9 probe_fail low", probe_fail, 0);
        chk("R5 hdr_type", hdr_type, {v.thi, v.tlo});
        chk("R5 block_exp", block_exp, v.blk);
        chk("R5 flash_exp", flash_exp, v.fl);
        chk("R5 access_ns", access_ns, v.ns);
        chk("R6 page_bytes", page_bytes, v.tlo[0] ? 2048 : 512);
        chk("R6 spare_bytes", spare_bytes, v.tlo[0] ? 64 : 16);
        chk("R6 addr_bytes", addr_bytes, 2 + int'(v.tlo[2:1]));
        if (v.boot) chk("R7 boot_sectors", boot_sectors, exp_boot);
        else        chk("R8 boot_sectors zero", boot_sectors, exp_boot);
        chk(v.boot ? "R7 no_boot_code low" : "R8 no_boot_code high", no_boot_code, !v.boot);
      end
    end

    // R10: hold while idle under input activity
    held = VECS[3];
    run_probe(held, tries);
    present = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      rd_data_valid = k[0];
      rd_data = 8'(k * 37);
      rd_req_ready = k[1];
    end
    rd_data_valid = 1'b0; rd_req_ready = 1'b0;
    @(negedge clk);
    chk("R10 done held", done, 1);
    chk("R10 hdr_valid held", hdr_valid, 1);
    chk("R10 boot_sectors held", boot_sectors, 17'd2);
    chk("R10 access_ns held", access_ns, 16'h0046);
    chk("R10 no request while idle", rd_req_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule